// File: doc/BRIEF.md
# Frame-Size-Adaptive Transmit/Receive Queue Pair

This block holds the transmit and receive word queues of a serial controller. Each queue can physically store 32 words of 32 bits. The number of words that may actually be used follows the configured frame width. Wide frames get a shallower queue and narrow frames a deeper one. When the large-queue option is off, both queues are held to four words.

The neighbouring shift engine pushes received words and pops words to transmit. The bus side pushes transmit words and pops received words. For each queue the block reports empty, almost-full and full. For the receive queue it also reports an overflow when a word had to be dropped. The frame-width value is kept here. It is written through a small write port that refuses widths above 32 and refuses any write while the controller is enabled. A synchronous soft reset and any change of usable depth both empty the queues.

Top module: `adaptive_fifo_pair`

## Requirements
- R1: After reset both queues are empty (empty flags 1, almost-full, full and overflow 0), the frame width reads 4 and the usable depth reads 4.
- R2: With the large-queue input high, the usable depth is 32 for frame widths 0 to 8, 16 for widths 9 to 16, and 8 for widths 17 to 32.
- R3: With the large-queue input low, the usable depth is 4 whatever the frame width.
- R4: A frame-width write is ignored if its value exceeds 32 or if the controller-enable input is high. An accepted write appears on the frame-width output one cycle later, and the depth follows one cycle after that.
- R5: A transmit push while the transmit queue holds the usable depth is ignored. The stored words and their order are unchanged.
- R6: A receive push while the receive queue holds the usable depth drops the word and sets the overflow flag one cycle later. The flag stays set until a receive pop removes a word.
- R7: Almost-full is 1 while occupancy is at least depth minus one. Full is 1 while occupancy equals the depth. Both fall once pops bring occupancy below those levels.
- R8: Each queue returns words in push order. Its data output always shows the oldest stored word, so no extra read cycle is needed.
- R9: A pop on an empty queue has no effect. The queue stays empty, and the next pushed word becomes the data output.
- R10: In the cycle after the usable depth changes, both queues are empty and the overflow flag is clear.
- R11: A soft reset empties both queues, clears the overflow flag and restores a frame width of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of queues and frame width |
| ctrl_en_i | input | 1 | Controller enabled; locks the frame width |
| big_en_i | input | 1 | Large-queue option |
| fsz_wr_i | input | 1 | Frame-width write strobe |
| fsz_wdata_i | input | 6 | Frame-width write value |
| fsz_o | output | 6 | Current frame width |
| depth_o | output | 6 | Current usable depth |
| tx_push_i | input | 1 | Transmit push |
| tx_data_i | input | 32 | Transmit push word |
| tx_pop_i | input | 1 | Transmit pop |
| tx_data_o | output | 32 | Oldest transmit word |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_afull_o | output | 1 | Transmit queue almost full |
| tx_full_o | output | 1 | Transmit queue full |
| rx_push_i | input | 1 | Receive push |
| rx_data_i | input | 32 | Receive push word |
| rx_pop_i | input | 1 | Receive pop |
| rx_data_o | output | 32 | Oldest receive word |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_afull_o | output | 1 | Receive queue almost full |
| rx_full_o | output | 1 | Receive queue full |
| rx_ovf_o | output | 1 | Receive word dropped since last pop |

## Verification
The hardest state to reach is a depth change while both queues hold data and the overflow flag is set. It needs a non-default width, a filled receive queue pushed past its limit, and then a toggle of the large-queue input. The stimulus first walks the frame width through every depth band. It then sets width 32, which gives depth 8. It overfills the receive queue and queues a few transmit words, then drops the large-queue input. The following cycle is checked for empty queues and a clear flag.

// File: rtl/afp_pkg.sv
`timescale 1ns/1ps
package afp_pkg;
  typedef struct packed {
    logic empty;
    logic afull;
    logic full;
  } qstat_t;
endpackage

// File: rtl/afp_depth_sel.sv
`timescale 1ns/1ps
module afp_depth_sel #(
  parameter int FSZ_W       = 6,
  parameter int FSZ_MAX     = 32,
  parameter int FSZ_RST     = 4,
  parameter int CNT_W       = 6,
  parameter int BIG_DEPTH   = 32,
  parameter int MID_DEPTH   = 16,
  parameter int WIDE_DEPTH  = 8,
  parameter int SMALL_DEPTH = 4,
  parameter int NARROW_LIM  = 8,
  parameter int MID_LIM     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             ctrl_en_i,
  input  logic             big_en_i,
  input  logic             fsz_wr_i,
  input  logic [FSZ_W-1:0] fsz_i,
  output logic [FSZ_W-1:0] fsz_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             flush_o
);
  localparam logic [FSZ_W-1:0] FszMaxV    = FSZ_W'(FSZ_MAX);
  localparam logic [FSZ_W-1:0] FszRstV    = FSZ_W'(FSZ_RST);
  localparam logic [FSZ_W-1:0] NarrowLimV = FSZ_W'(NARROW_LIM);
  localparam logic [FSZ_W-1:0] MidLimV    = FSZ_W'(MID_LIM);

  logic [FSZ_W-1:0] fsz_q;
  logic [CNT_W-1:0] depth_q, depth_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      fsz_q <= FszRstV;
    else if (soft_rst_i)                              fsz_q <= FszRstV;
    else if (fsz_wr_i && !ctrl_en_i && fsz_i <= FszMaxV) fsz_q <= fsz_i;
  end

  always_comb begin
    if (!big_en_i)                depth_d = CNT_W'(SMALL_DEPTH);
    else if (fsz_q <= NarrowLimV) depth_d = CNT_W'(BIG_DEPTH);
    else if (fsz_q <= MidLimV)    depth_d = CNT_W'(MID_DEPTH);
    else                          depth_d = CNT_W'(WIDE_DEPTH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= CNT_W'(SMALL_DEPTH);
    else         depth_q <= depth_d;
  end

  // queues are emptied on the edge that takes the new depth
  assign flush_o = (depth_d != depth_q);
  assign fsz_o   = fsz_q;
  assign depth_o = depth_q;
endmodule

// File: rtl/afp_queue.sv
`timescale 1ns/1ps
module afp_queue
  import afp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CAP    = 32,
  parameter int CNT_W  = 6,
  parameter bit OVF_EN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  depth_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output qstat_t            stat_o,
  output logic              ovf_o
);
  localparam int PTR_W = $clog2(CAP);

  logic [DATA_W-1:0] mem [CAP];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              full_w, do_push, do_pop;

  assign full_w  = (count_q >= depth_i);
  assign do_push = push_i && !full_w;
  assign do_pop  = pop_i && (count_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      count_q <= count_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wr_ptr_q] <= data_i;
  end

  assign data_o       = mem[rd_ptr_q];
  assign stat_o.empty = (count_q == '0);
  assign stat_o.afull = (count_q >= depth_i - CNT_W'(1));
  assign stat_o.full  = full_w;

  generate
    if (OVF_EN) begin : g_ovf
      logic ovf_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               ovf_q <= 1'b0;
        else if (clr_i)            ovf_q <= 1'b0;
        else if (push_i && full_w) ovf_q <= 1'b1;
        else if (do_pop)           ovf_q <= 1'b0;
      end
      assign ovf_o = ovf_q;
    end else begin : g_no_ovf
      assign ovf_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/adaptive_fifo_pair.sv
`timescale 1ns/1ps
module adaptive_fifo_pair
  import afp_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CAP         = 32,
  parameter int FSZ_W       = 6,
  parameter int FSZ_MAX     = 32,
  parameter int FSZ_RST     = 4,
  parameter int SMALL_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              ctrl_en_i,
  input  logic              big_en_i,
  input  logic              fsz_wr_i,
  input  logic [FSZ_W-1:0]  fsz_wdata_i,
  output logic [FSZ_W-1:0]  fsz_o,
  output logic [5:0]        depth_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_empty_o,
  output logic              tx_afull_o,
  output logic              tx_full_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_empty_o,
  output logic              rx_afull_o,
  output logic              rx_full_o,
  output logic              rx_ovf_o
);
  localparam int CNT_W = 6;
  localparam int NQ    = 2;  // lane 0 transmit, lane 1 receive

  logic [CNT_W-1:0]  depth;
  logic              flush, clr;
  logic              push [NQ];
  logic              pop  [NQ];
  logic [DATA_W-1:0] din  [NQ];
  logic [DATA_W-1:0] dout [NQ];
  qstat_t            stat [NQ];
  logic [NQ-1:0]     ovf;

  afp_depth_sel #(
    .FSZ_W(FSZ_W), .FSZ_MAX(FSZ_MAX), .FSZ_RST(FSZ_RST), .CNT_W(CNT_W),
    .BIG_DEPTH(CAP), .MID_DEPTH(CAP/2), .WIDE_DEPTH(CAP/4),
    .SMALL_DEPTH(SMALL_DEPTH), .NARROW_LIM(8), .MID_LIM(16)
  ) u_depth (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .ctrl_en_i(ctrl_en_i), .big_en_i(big_en_i), .fsz_wr_i(fsz_wr_i),
    .fsz_i(fsz_wdata_i), .fsz_o(fsz_o), .depth_o(depth), .flush_o(flush)
  );

  assign clr = flush || soft_rst_i;

  assign push[0] = tx_push_i;  assign din[0] = tx_data_i;  assign pop[0] = tx_pop_i;
  assign push[1] = rx_push_i;  assign din[1] = rx_data_i;  assign pop[1] = rx_pop_i;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    afp_queue #(
      .DATA_W(DATA_W), .CAP(CAP), .CNT_W(CNT_W), .OVF_EN(q == 1)
    ) u_queue (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .depth_i(depth),
      .push_i(push[q]), .data_i(din[q]), .pop_i(pop[q]),
      .data_o(dout[q]), .stat_o(stat[q]), .ovf_o(ovf[q])
    );
  end

  assign depth_o    = depth;
  assign tx_data_o  = dout[0];
  assign tx_empty_o = stat[0].empty;
  assign tx_afull_o = stat[0].afull;
  assign tx_full_o  = stat[0].full;
  assign rx_data_o  = dout[1];
  assign rx_empty_o = stat[1].empty;
  assign rx_afull_o = stat[1].afull;
  assign rx_full_o  = stat[1].full;
  assign rx_ovf_o   = |ovf;  // transmit lane ties its flag low
endmodule

// File: rtl/afp_chk.sv
`timescale 1ns/1ps
module afp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       ctrl_en_i,
  input logic [5:0] fsz_o,
  input logic [5:0] depth_o,
  input logic       tx_push_i,
  input logic       tx_pop_i,
  input logic       tx_empty_o,
  input logic       tx_afull_o,
  input logic       tx_full_o,
  input logic       rx_push_i,
  input logic       rx_pop_i,
  input logic       rx_empty_o,
  input logic       rx_full_o,
  input logic       rx_ovf_o
);
  // R4
  fsz_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en_i && !soft_rst_i) |=> $stable(fsz_o));
  // R4
  fsz_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsz_o <= 6'd32);
  // R2
  depth_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(depth_o) == 1 && depth_o >= 6'd4);
  // R5
  tx_hold_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_o && tx_push_i && !tx_pop_i && !soft_rst_i) |=> (tx_full_o || !$stable(depth_o)));
  // R6
  rx_ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && rx_push_i && !soft_rst_i) |=> (rx_ovf_o || !$stable(depth_o)));
  // R6
  rx_ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_o && !rx_pop_i && !soft_rst_i) |=> (rx_ovf_o || !$stable(depth_o)));
  // R7
  tx_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> (tx_afull_o && !tx_empty_o));
  // R9
  rx_empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_o && !rx_push_i) |=> rx_empty_o);
endmodule

bind adaptive_fifo_pair afp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .ctrl_en_i(ctrl_en_i),
  .fsz_o(fsz_o), .depth_o(depth_o),
  .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i), .tx_empty_o(tx_empty_o),
  .tx_afull_o(tx_afull_o), .tx_full_o(tx_full_o),
  .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i), .rx_empty_o(rx_empty_o),
  .rx_full_o(rx_full_o), .rx_ovf_o(rx_ovf_o)
);

// File: tb/adaptive_fifo_pair_tb.sv
`timescale 1ns/1ps
module adaptive_fifo_pair_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, ctrl_en = 0, big_en = 0, fsz_wr = 0;
  logic [5:0] fsz_wdata = '0, fsz, depth;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [31:0] tx_din = '0, rx_din = '0, tx_dout, rx_dout;
  logic tx_empty, tx_afull, tx_full, rx_empty, rx_afull, rx_full, rx_ovf;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  adaptive_fifo_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .ctrl_en_i(ctrl_en),
    .big_en_i(big_en), .fsz_wr_i(fsz_wr), .fsz_wdata_i(fsz_wdata),
    .fsz_o(fsz), .depth_o(depth),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .tx_empty_o(tx_empty), .tx_afull_o(tx_afull), .tx_full_o(tx_full),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .rx_empty_o(rx_empty), .rx_afull_o(rx_afull), .rx_full_o(rx_full), .rx_ovf_o(rx_ovf)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [31:0] d);
    tx_push = 1; tx_din = d; step(); tx_push = 0;
  endtask
  task automatic push_rx(input logic [31:0] d);
    rx_push = 1; rx_din = d; step(); rx_push = 0;
  endtask
  task automatic pop_tx();
    tx_pop = 1; step(); tx_pop = 0;
  endtask
  task automatic pop_rx();
    rx_pop = 1; step(); rx_pop = 0;
  endtask
  task automatic wr_fsz(input logic [5:0] v);
    fsz_wr = 1; fsz_wdata = v; step(); fsz_wr = 0; step();
  endtask

  task automatic t_reset();
    chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_full", tx_full, 0);   chk("R1 tx_afull", tx_afull, 0);
    chk("R1 rx_full", rx_full, 0);   chk("R1 rx_ovf", rx_ovf, 0);
    chk("R1 fsz", fsz, 4);           chk("R1 depth", depth, 4);
  endtask

  task automatic t_small_tx();
    chk("R3 depth small", depth, 4);
    for (int i = 0; i < 5; i++) begin
      push_tx(32'hA0 + i);
      if (i == 2) begin chk("R7 afull at 3", tx_afull, 1); chk("R7 not full at 3", tx_full, 0); end
      if (i >= 3) chk("R5 full", tx_full, 1);
    end
    for (int i = 0; i < 4; i++) begin
      chk("R8 R5 tx order", tx_dout, 32'hA0 + i);
      pop_tx();
      if (i == 0) begin chk("R7 full clears", tx_full, 0); chk("R7 afull holds", tx_afull, 1); end
      if (i == 1) chk("R7 afull clears", tx_afull, 0);
    end
    chk("R5 dropped word absent", tx_empty, 1);
    pop_tx();
    chk("R9 empty after idle pop", tx_empty, 1);
    push_tx(32'h55);
    chk("R9 next word out", tx_dout, 32'h55);
    chk("R9 not empty", tx_empty, 0);
    pop_tx();
  endtask

  task automatic t_rx_ovf();
    for (int i = 0; i < 5; i++) begin
      push_rx(32'hB0 + i);
      if (i == 3) chk("R6 no ovf at full", rx_ovf, 0);
    end
    chk("R6 ovf set", rx_ovf, 1);
    step();
    chk("R6 ovf holds", rx_ovf, 1);
    chk("R8 rx head", rx_dout, 32'hB0);
    pop_rx();
    chk("R6 ovf cleared by pop", rx_ovf, 0);
    for (int i = 1; i < 4; i++) begin
      chk("R8 rx order", rx_dout, 32'hB0 + i);
      pop_rx();
    end
    chk("R6 dropped word absent", rx_empty, 1);
  endtask

  task automatic t_depth();
    big_en = 1; step();
    chk("R2 fsz4 depth", depth, 32);
    wr_fsz(8);  chk("R2 fsz8", depth, 32);
    wr_fsz(9);  chk("R2 fsz9", depth, 16);
    wr_fsz(16); chk("R2 fsz16", depth, 16);
    wr_fsz(17); chk("R2 fsz17", depth, 8);
    wr_fsz(32); chk("R2 fsz32", depth, 8);
    wr_fsz(33); chk("R4 too large ignored", fsz, 32);
    ctrl_en = 1; wr_fsz(5); ctrl_en = 0;
    chk("R4 locked while enabled", fsz, 32);
    chk("R4 depth unchanged", depth, 8);
  endtask

  task automatic t_big_fill();
    for (int i = 0; i < 9; i++) begin
      push_tx(32'hC0 + i);
      if (i == 6) begin chk("R7 afull at 7", tx_afull, 1); chk("R7 not full at 7", tx_full, 0); end
      if (i == 7) chk("R7 full at 8", tx_full, 1);
    end
    for (int i = 0; i < 8; i++) begin
      chk("R8 R5 big order", tx_dout, 32'hC0 + i);
      pop_tx();
    end
    chk("R5 ninth dropped", tx_empty, 1);
  endtask

  task automatic t_flush();
    push_tx(32'h11); push_tx(32'h22);
    for (int i = 0; i < 9; i++) push_rx(32'hD0 + i);
    chk("R6 ovf before flush", rx_ovf, 1);
    big_en = 0; step();
    chk("R10 R3 depth", depth, 4);
    chk("R10 tx flushed", tx_empty, 1);
    chk("R10 rx flushed", rx_empty, 1);
    chk("R10 ovf cleared", rx_ovf, 0);
  endtask

  task automatic t_soft();
    wr_fsz(20);
    chk("R3 depth ignores fsz", depth, 4);
    push_tx(32'h77); push_rx(32'h88);
    soft_rst = 1; step(); soft_rst = 0;
    chk("R11 fsz restored", fsz, 4);
    chk("R11 tx empty", tx_empty, 1);
    chk("R11 rx empty", rx_empty, 1);
    big_en = 1; step();
    chk("R11 R2 depth after soft", depth, 32);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_small_tx();
    t_rx_ovf();
    t_depth();
    t_big_fill();
    t_flush();
    t_soft();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule